// File: doc/BRIEF.md
# Scan Window Offset Sequencer

The sequencer sits behind a handle position generator and expands each handle (x, y) it accepts into the list of memory accesses that make up one scan window. A window is a short list of entries. Each entry holds a signed x and y offset and a direction code. For each entry, the block adds the offset to the handle and tags the access as a read, a write, or a read followed by a write. It then routes the access to one of two memory banks that hold alternate rows.

The table holds sixteen windows at once and is loaded through a simple write port. The central control selects the active window with a command. The new choice applies from the next handle onward and never part-way through a window. A finite state machine walks the chosen window entry by entry. Handles are accepted with valid/ready, and each bank has its own valid/ready access port.

Top module: `swin_seq`

## Requirements
- R1: Each element address is the handle coordinate plus the entry's offset sign-extended from 8 bits, taken modulo 2^COORD_W, separately for x and y.
- R2: Direction code 2'b01 issues one read (bank_wr_o low). Code 2'b10 issues one write (bank_wr_o high). Code 2'b11 issues a read and then, as the next access, a write to the same address. Code 2'b00 is issued as a read.
- R3: The table holds 16 windows of up to 8 entries. The entry count is stored as n-1 in 3 bits (tbl_cnt_i = 7 means eight entries), and entry fields are written through tbl_we_i at window tbl_win_i, index tbl_idx_i.
- R4: For every accepted handle, the entries of its window are issued in index order 0 to n-1, each exactly once (twice for code 2'b11).
- R5: An access goes to bank b only when bit 0 of its y address equals b. bank_valid_o[b] is never high for the other bank, and bank b's address sits in bits [b*COORD_W +: COORD_W] of bank_x_o and bank_y_o.
- R6: While the target bank's ready is low, the access stays valid with unchanged address and direction. When ready is high, the access is taken and the next one follows in the next cycle.
- R7: hdl_ready_o is high only when no access of the previous handle is outstanding. It rises in the cycle after the last access is accepted, and an accepted handle shows its first access in the next cycle.
- R8: A pulse on win_sel_we_i stores win_sel_i. A handle uses the selection stored before the cycle in which it is accepted, and a selection made while a window is in progress does not alter that window.
- R9: After reset, hdl_ready_o is high, no bank valid is high, window 0 is selected, and every window holds one entry with zero offsets and code 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdl_valid_i | input | 1 | Handle valid |
| hdl_ready_o | output | 1 | Handle accepted when high with valid |
| hdl_x_i | input | COORD_W | Handle x coordinate |
| hdl_y_i | input | COORD_W | Handle y coordinate |
| win_sel_we_i | input | 1 | Window-select command strobe |
| win_sel_i | input | WIN_W | Window to use from the next handle |
| tbl_we_i | input | 1 | Entry write strobe |
| tbl_win_i | input | WIN_W | Window written by either table strobe |
| tbl_idx_i | input | IDX_W | Entry index written |
| tbl_dx_i | input | 8 | Signed x offset |
| tbl_dy_i | input | 8 | Signed y offset |
| tbl_dir_i | input | 2 | Direction code |
| tbl_cnt_we_i | input | 1 | Entry-count write strobe |
| tbl_cnt_i | input | IDX_W | Entry count minus one |
| bank_valid_o | output | 2 | Access valid, per bank |
| bank_ready_i | input | 2 | Bank accepts access |
| bank_x_o | output | 2*COORD_W | Element x per bank |
| bank_y_o | output | 2*COORD_W | Element y per bank |
| bank_wr_o | output | 2 | 1 = write, 0 = read, per bank |

## Verification
The assertions take for granted that a bank's ready can drop at any time. They also take for granted that the table is not rewritten for the window in progress while a handle is being expanded, because the sequencer reads entries live. The bench loads the table and issues select commands only between handles, except in the deliberate mid-window select test, which changes only the select register. Bank ready is driven both always-high and from a pseudo-random sequence. This exercises stalls on either bank and on the second half of read-then-write entries.

// File: rtl/swin_pkg.sv
package swin_pkg;
  localparam int OFS_W = 8;
  localparam int DIR_W = 2;

  typedef enum logic [DIR_W-1:0] {
    DIR_NONE = 2'b00,
    DIR_RD   = 2'b01,
    DIR_WR   = 2'b10,
    DIR_RW   = 2'b11
  } swin_dir_e;

  typedef struct packed {
    logic signed [OFS_W-1:0] dx;
    logic signed [OFS_W-1:0] dy;
    swin_dir_e               dir;
  } swin_ent_t;
endpackage

// File: rtl/swin_table.sv
module swin_table
  import swin_pkg::*;
#(
  parameter int N_WIN   = 16,
  parameter int MAX_ENT = 8,
  localparam int WIN_W  = $clog2(N_WIN),
  localparam int IDX_W  = $clog2(MAX_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WIN_W-1:0] wr_win_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  swin_ent_t        wr_ent_i,
  input  logic             cnt_we_i,
  input  logic [IDX_W-1:0] wr_cnt_i,
  input  logic [WIN_W-1:0] rd_win_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output swin_ent_t        rd_ent_o,
  output logic [IDX_W-1:0] rd_last_o
);
  localparam int N_ENT = N_WIN * MAX_ENT;

  swin_ent_t        ent_q [N_ENT];
  logic [IDX_W-1:0] last_q [N_WIN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENT; i++) ent_q[i] <= '0;
      for (int w = 0; w < N_WIN; w++) last_q[w] <= '0;
    end else begin
      if (we_i)     ent_q[{wr_win_i, wr_idx_i}] <= wr_ent_i;
      if (cnt_we_i) last_q[wr_win_i]            <= wr_cnt_i;
    end
  end

  assign rd_ent_o  = ent_q[{rd_win_i, rd_idx_i}];
  assign rd_last_o = last_q[rd_win_i];
endmodule

// File: rtl/swin_addgen.sv
module swin_addgen
  import swin_pkg::*;
#(
  parameter int COORD_W = 16
) (
  input  logic [COORD_W-1:0] hx_i,
  input  logic [COORD_W-1:0] hy_i,
  input  swin_ent_t          ent_i,
  output logic [COORD_W-1:0] ex_o,
  output logic [COORD_W-1:0] ey_o,
  output logic               bank_o
);
  localparam int EXT_W = COORD_W - OFS_W;

  assign ex_o   = hx_i + {{EXT_W{ent_i.dx[OFS_W-1]}}, ent_i.dx};
  assign ey_o   = hy_i + {{EXT_W{ent_i.dy[OFS_W-1]}}, ent_i.dy};
  assign bank_o = ey_o[0];
endmodule

// File: rtl/swin_fsm.sv
module swin_fsm
  import swin_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int N_WIN   = 16,
  parameter int MAX_ENT = 8,
  localparam int WIN_W  = $clog2(N_WIN),
  localparam int IDX_W  = $clog2(MAX_ENT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hdl_valid_i,
  output logic               hdl_ready_o,
  input  logic [COORD_W-1:0] hdl_x_i,
  input  logic [COORD_W-1:0] hdl_y_i,
  input  logic [WIN_W-1:0]   sel_win_i,
  output logic [WIN_W-1:0]   lk_win_o,
  output logic [IDX_W-1:0]   lk_idx_o,
  output logic [COORD_W-1:0] lk_hx_o,
  output logic [COORD_W-1:0] lk_hy_o,
  input  swin_ent_t          lk_ent_i,
  input  logic [IDX_W-1:0]   lk_last_i,
  input  logic [COORD_W-1:0] ex_i,
  input  logic [COORD_W-1:0] ey_i,
  input  logic               ebank_i,
  input  logic [1:0]         bank_ready_i,
  output logic               acc_valid_o,
  output logic               acc_bank_o,
  output logic [COORD_W-1:0] acc_x_o,
  output logic [COORD_W-1:0] acc_y_o,
  output logic               acc_wr_o
);
  logic               acc_valid_q, acc_bank_q, acc_wr_q, rw_pend_q;
  logic [COORD_W-1:0] acc_x_q, acc_y_q, hx_q, hy_q;
  logic [WIN_W-1:0]   win_q;
  logic [IDX_W-1:0]   idx_q, last_q;
  logic               acc_fire, load;

  assign hdl_ready_o = !acc_valid_q;
  assign acc_fire    = acc_valid_q && bank_ready_i[acc_bank_q];
  assign load        = (hdl_valid_i && !acc_valid_q) ||
                       (acc_fire && !rw_pend_q && idx_q != last_q);

  // idle: look up entry 0 of the selected window at the incoming handle
  assign lk_win_o = acc_valid_q ? win_q : sel_win_i;
  assign lk_idx_o = acc_valid_q ? idx_q + 1'b1 : '0;
  assign lk_hx_o  = acc_valid_q ? hx_q : hdl_x_i;
  assign lk_hy_o  = acc_valid_q ? hy_q : hdl_y_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_valid_q <= 1'b0;
      acc_bank_q  <= 1'b0;
      acc_wr_q    <= 1'b0;
      rw_pend_q   <= 1'b0;
      acc_x_q     <= '0;
      acc_y_q     <= '0;
      hx_q        <= '0;
      hy_q        <= '0;
      win_q       <= '0;
      idx_q       <= '0;
      last_q      <= '0;
    end else begin
      if (!acc_valid_q && hdl_valid_i) begin
        win_q  <= sel_win_i;
        hx_q   <= hdl_x_i;
        hy_q   <= hdl_y_i;
        idx_q  <= '0;
        last_q <= lk_last_i;
      end else if (load) begin
        idx_q <= idx_q + 1'b1;
      end
      if (load) begin
        acc_valid_q <= 1'b1;
        acc_x_q     <= ex_i;
        acc_y_q     <= ey_i;
        acc_bank_q  <= ebank_i;
        acc_wr_q    <= (lk_ent_i.dir == DIR_WR);
        rw_pend_q   <= (lk_ent_i.dir == DIR_RW);
      end else if (acc_fire && rw_pend_q) begin
        acc_wr_q  <= 1'b1;
        rw_pend_q <= 1'b0;
      end else if (acc_fire) begin
        acc_valid_q <= 1'b0;
      end
    end
  end

  assign acc_valid_o = acc_valid_q;
  assign acc_bank_o  = acc_bank_q;
  assign acc_x_o     = acc_x_q;
  assign acc_y_o     = acc_y_q;
  assign acc_wr_o    = acc_wr_q;

  a_r6_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_q && !bank_ready_i[acc_bank_q]) |=>
      (acc_valid_q && $stable(acc_x_q) && $stable(acc_y_q) && $stable(acc_wr_q)
       && $stable(acc_bank_q)));

  a_r2_rw_second_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_fire && rw_pend_q) |=>
      (acc_valid_q && acc_wr_q && $stable(acc_x_q) && $stable(acc_y_q)));

  a_r7_accept_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdl_valid_i && hdl_ready_o) |=> (acc_valid_q && !hdl_ready_o));

  a_r8_window_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_q && $past(acc_valid_q)) |-> $stable(win_q));
endmodule

// File: rtl/swin_seq.sv
module swin_seq
  import swin_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int N_WIN   = 16,
  parameter int MAX_ENT = 8,
  localparam int WIN_W  = $clog2(N_WIN),
  localparam int IDX_W  = $clog2(MAX_ENT)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   hdl_valid_i,
  output logic                   hdl_ready_o,
  input  logic [COORD_W-1:0]     hdl_x_i,
  input  logic [COORD_W-1:0]     hdl_y_i,
  input  logic                   win_sel_we_i,
  input  logic [WIN_W-1:0]       win_sel_i,
  input  logic                   tbl_we_i,
  input  logic [WIN_W-1:0]       tbl_win_i,
  input  logic [IDX_W-1:0]       tbl_idx_i,
  input  logic [OFS_W-1:0]       tbl_dx_i,
  input  logic [OFS_W-1:0]       tbl_dy_i,
  input  logic [DIR_W-1:0]       tbl_dir_i,
  input  logic                   tbl_cnt_we_i,
  input  logic [IDX_W-1:0]       tbl_cnt_i,
  output logic [1:0]             bank_valid_o,
  input  logic [1:0]             bank_ready_i,
  output logic [2*COORD_W-1:0]   bank_x_o,
  output logic [2*COORD_W-1:0]   bank_y_o,
  output logic [1:0]             bank_wr_o
);
  logic [WIN_W-1:0]   sel_q, lk_win;
  logic [IDX_W-1:0]   lk_idx, lk_last;
  logic [COORD_W-1:0] lk_hx, lk_hy, ex, ey, acc_x, acc_y;
  logic               ebank, acc_valid, acc_bank, acc_wr;
  swin_ent_t          wr_ent, lk_ent;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           sel_q <= '0;
    else if (win_sel_we_i) sel_q <= win_sel_i;
  end

  assign wr_ent = '{dx: tbl_dx_i, dy: tbl_dy_i, dir: swin_dir_e'(tbl_dir_i)};

  swin_table #(.N_WIN(N_WIN), .MAX_ENT(MAX_ENT)) u_table (
    .clk_i, .rst_ni,
    .we_i(tbl_we_i), .wr_win_i(tbl_win_i), .wr_idx_i(tbl_idx_i), .wr_ent_i(wr_ent),
    .cnt_we_i(tbl_cnt_we_i), .wr_cnt_i(tbl_cnt_i),
    .rd_win_i(lk_win), .rd_idx_i(lk_idx), .rd_ent_o(lk_ent), .rd_last_o(lk_last)
  );

  swin_addgen #(.COORD_W(COORD_W)) u_addgen (
    .hx_i(lk_hx), .hy_i(lk_hy), .ent_i(lk_ent), .ex_o(ex), .ey_o(ey), .bank_o(ebank)
  );

  swin_fsm #(.COORD_W(COORD_W), .N_WIN(N_WIN), .MAX_ENT(MAX_ENT)) u_fsm (
    .clk_i, .rst_ni,
    .hdl_valid_i, .hdl_ready_o, .hdl_x_i, .hdl_y_i,
    .sel_win_i(sel_q),
    .lk_win_o(lk_win), .lk_idx_o(lk_idx), .lk_hx_o(lk_hx), .lk_hy_o(lk_hy),
    .lk_ent_i(lk_ent), .lk_last_i(lk_last),
    .ex_i(ex), .ey_i(ey), .ebank_i(ebank),
    .bank_ready_i,
    .acc_valid_o(acc_valid), .acc_bank_o(acc_bank),
    .acc_x_o(acc_x), .acc_y_o(acc_y), .acc_wr_o(acc_wr)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign bank_valid_o[b]                    = acc_valid && (acc_bank == b[0]);
    assign bank_x_o[b*COORD_W +: COORD_W]     = acc_x;
    assign bank_y_o[b*COORD_W +: COORD_W]     = acc_y;
    assign bank_wr_o[b]                       = acc_wr;

    a_r5_bank_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bank_valid_o[b] |-> (bank_y_o[b*COORD_W] == b[0]));
  end
endmodule

// File: tb/tb_swin_seq.sv
module tb_swin_seq;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hdl_valid = 1'b0, hdl_ready;
  logic [CW-1:0] hdl_x = '0, hdl_y = '0;
  logic          win_sel_we = 1'b0;
  logic [3:0]    win_sel = '0;
  logic          tbl_we = 1'b0, tbl_cnt_we = 1'b0;
  logic [3:0]    tbl_win = '0;
  logic [2:0]    tbl_idx = '0, tbl_cnt = '0;
  logic [7:0]    tbl_dx = '0, tbl_dy = '0;
  logic [1:0]    tbl_dir = '0;
  logic [1:0]    bank_valid, bank_ready = 2'b11, bank_wr;
  logic [2*CW-1:0] bank_x, bank_y;

  swin_seq dut (
    .clk_i(clk), .rst_ni(rst_n),
    .hdl_valid_i(hdl_valid), .hdl_ready_o(hdl_ready), .hdl_x_i(hdl_x), .hdl_y_i(hdl_y),
    .win_sel_we_i(win_sel_we), .win_sel_i(win_sel),
    .tbl_we_i(tbl_we), .tbl_win_i(tbl_win), .tbl_idx_i(tbl_idx),
    .tbl_dx_i(tbl_dx), .tbl_dy_i(tbl_dy), .tbl_dir_i(tbl_dir),
    .tbl_cnt_we_i(tbl_cnt_we), .tbl_cnt_i(tbl_cnt),
    .bank_valid_o(bank_valid), .bank_ready_i(bank_ready),
    .bank_x_o(bank_x), .bank_y_o(bank_y), .bank_wr_o(bank_wr)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;

  typedef struct { logic b; logic [CW-1:0] x, y; logic w; } exp_t;
  exp_t q[$];

  logic [7:0] m_dx [16][8];
  logic [7:0] m_dy [16][8];
  logic [1:0] m_dir[16][8];
  int         m_n  [16];
  int         m_sel = 0;
  int         rdy_mode = 0;
  logic [7:0] lfsr = 8'h5a;

  function automatic void check(bit ok, string tag, string act, string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %s expected %s", tag, act, exp);
    end
  endfunction

  task automatic wr_ent(int w, int i, logic [7:0] dx, logic [7:0] dy, logic [1:0] dir);
    @(negedge clk);
    tbl_we = 1; tbl_win = w[3:0]; tbl_idx = i[2:0]; tbl_dx = dx; tbl_dy = dy; tbl_dir = dir;
    @(posedge clk); #1 tbl_we = 0;
    m_dx[w][i] = dx; m_dy[w][i] = dy; m_dir[w][i] = dir;
  endtask

  task automatic wr_cnt(int w, int n);
    @(negedge clk);
    tbl_cnt_we = 1; tbl_win = w[3:0]; tbl_cnt = 3'(n - 1);
    @(posedge clk); #1 tbl_cnt_we = 0;
    m_n[w] = n;
  endtask

  task automatic select(int w);
    @(negedge clk);
    win_sel_we = 1; win_sel = w[3:0];
    @(posedge clk); #1 win_sel_we = 0;
    m_sel = w;
  endtask

  // driver: present a handle, push expected accesses once accepted
  task automatic send(logic [CW-1:0] hx, logic [CW-1:0] hy);
    @(negedge clk);
    hdl_valid = 1; hdl_x = hx; hdl_y = hy;
    forever begin
      #1;
      if (hdl_ready) break;
      @(negedge clk);
    end
    @(posedge clk); #1 hdl_valid = 0;
    for (int i = 0; i < m_n[m_sel]; i++) begin
      exp_t e;
      e.x = hx + {{8{m_dx[m_sel][i][7]}}, m_dx[m_sel][i]};
      e.y = hy + {{8{m_dy[m_sel][i][7]}}, m_dy[m_sel][i]};
      e.b = e.y[0];
      e.w = (m_dir[m_sel][i] == 2'b10);
      q.push_back(e);
      if (m_dir[m_sel][i] == 2'b11) begin
        e.w = 1'b1;
        q.push_back(e);
      end
    end
  endtask

  task automatic drain();
    do @(negedge clk); while (q.size() != 0);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (rdy_mode == 0) bank_ready <= 2'b11;
    else               bank_ready <= lfsr[1:0];
  end

  // monitor
  logic [1:0]    pv = '0, pr = '0;
  logic [CW-1:0] px[2], py[2];
  logic          pw[2];
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      check(hdl_ready == (q.size() == 0), "R7 handle ready",
            $sformatf("%0b", hdl_ready), $sformatf("%0b", q.size() == 0));
      check(!(bank_valid == 2'b11), "R5 one bank", $sformatf("%b", bank_valid), "not 11");
      for (int b = 0; b < 2; b++) begin
        logic [CW-1:0] ax, ay;
        ax = bank_x[b*CW +: CW];
        ay = bank_y[b*CW +: CW];
        if (pv[b] && !pr[b])
          check(bank_valid[b] && ax == px[b] && ay == py[b] && bank_wr[b] == pw[b],
                "R6 stall hold", $sformatf("v%0b %h,%h w%0b", bank_valid[b], ax, ay, bank_wr[b]),
                $sformatf("v1 %h,%h w%0b", px[b], py[b], pw[b]));
        if (bank_valid[b] && bank_ready[b]) begin
          if (q.size() == 0) begin
            check(0, "R4 extra access", $sformatf("b%0d %h,%h", b, ax, ay), "none");
          end else begin
            exp_t e;
            e = q.pop_front();
            check(e.b == b[0] && e.x == ax && e.y == ay && e.w == bank_wr[b],
                  "R1 R2 R4 R5 access",
                  $sformatf("b%0d %h,%h w%0b", b, ax, ay, bank_wr[b]),
                  $sformatf("b%0d %h,%h w%0b", e.b, e.x, e.y, e.w));
          end
        end
        px[b] = ax; py[b] = ay; pw[b] = bank_wr[b];
      end
      pv = bank_valid; pr = bank_ready;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired, actual hung, expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int w = 0; w < 16; w++) begin
      m_n[w] = 1;
      for (int i = 0; i < 8; i++) begin m_dx[w][i] = 0; m_dy[w][i] = 0; m_dir[w][i] = 0; end
    end
    repeat (3) @(negedge clk);
    #1;
    check(hdl_ready == 1'b1, "R9 reset ready", $sformatf("%0b", hdl_ready), "1");
    check(bank_valid == 2'b00, "R9 reset valid", $sformatf("%b", bank_valid), "00");
    rst_n = 1;

    // R9: untouched window 0 -> one read at the handle itself
    send(16'h0123, 16'h0041);
    drain();

    // R3 R1 R2: window 1, six entries, mixed codes and signs, wrap-around
    wr_ent(1, 0,  8'd2,    8'd0,   2'b01);
    wr_ent(1, 1,  8'hff,   8'd1,   2'b10);
    wr_ent(1, 2,  8'd0,    8'hfe,  2'b11);
    wr_ent(1, 3,  8'h7f,   8'h80,  2'b01);
    wr_ent(1, 4,  8'd5,    8'd3,   2'b00);
    wr_ent(1, 5,  8'h80,   8'd7,   2'b11);
    wr_cnt(1, 6);
    select(1);
    send(16'hfffe, 16'h0001);
    send(16'h0010, 16'h0020);
    drain();

    // R3: full window of eight entries, random bank stalls (R6)
    for (int i = 0; i < 8; i++)
      wr_ent(15, i, 8'(i * 3 - 9), 8'(i), 2'(i % 4));
    wr_cnt(15, 8);
    select(15);
    rdy_mode = 1;
    for (int k = 0; k < 6; k++) send(16'(k * 37), 16'(k * 11 + 1));
    drain();

    // R8: select changes while a window is in progress
    wr_ent(2, 0, 8'd1, 8'd1, 2'b11);
    wr_cnt(2, 1);
    send(16'h4000, 16'h4000);
    select(2);
    send(16'h5000, 16'h5001);
    send(16'h6000, 16'h6000);
    drain();

    // back-to-back with both banks ready (R6 throughput)
    rdy_mode = 0;
    select(1);
    for (int k = 0; k < 4; k++) send(16'(k * 100), 16'(k * 3));
    drain();

    check(q.size() == 0, "R4 all issued", $sformatf("%0d", q.size()), "0");
    summary();
    $finish;
  end
endmodule